// File: doc/BRIEF.md
# Retransmit FIFO, 512 x 9

This block is a single-device first-in first-out buffer that holds 512 words of 9 bits. A producer pushes words with an active-low write strobe and a consumer pulls them with an active-low read strobe. Three active-low status outputs report the fill level: empty, full and more than half full. All strobes are sampled once per cycle on a single clock, and each acts as a one-cycle enable.

An active-low retransmit input moves the read side back to the first location of the array and leaves the write side where it is. Words that were already consumed can then be read a second time, with no effect on the producer. An active-low reset clears both sides. Reset takes priority over retransmit, and retransmit takes priority over normal traffic. The read port is registered, and it keeps the last word delivered until the next accepted read.

Top module: `fifo_rt`

## Requirements
- R1: Words leave in the order they were written, with all 9 bits intact, across the full 512-word capacity and across address wrap-around.
- R2: While rst_n is low, the next edge sets the read and write addresses and the occupancy to zero and clears dout to 0. The flags then read empty_n=0, full_n=1 and half_n=1.
- R3: A write is taken only while full_n is high. A write strobe while full leaves the stored data, the occupancy and every output unchanged.
- R4: A read is taken only while empty_n is high. A read strobe while empty leaves dout, the occupancy and every output unchanged.
- R5: empty_n is low exactly when the occupancy is 0. full_n is low exactly when the occupancy is 512.
- R6: half_n is low exactly when the occupancy is 257 or more. It is high at 256 or fewer.
- R7: With rst_n high and rt_n low, the next edge sets the read address to 0 and keeps the write address. The occupancy becomes the write address value (0..511), and both strobes are ignored in that cycle.
- R8: dout changes only on the edge that takes a read, which loads the word at the read address. At every other edge dout holds its value.
- R9: When both strobes are active in one cycle, each one is taken or refused by its own flag. When neither flag blocks, the occupancy is unchanged. When full, only the read is taken. When empty, only the write is taken.
- R10: Reset wins over retransmit and over both strobes when they are active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low retransmit (rewind read address) |
| din | input | 9 | Write data |
| dout | output | 9 | Registered read data |
| empty_n | output | 1 | Low when no words are held |
| full_n | output | 1 | Low when 512 words are held |
| half_n | output | 1 | Low when 257 or more words are held |

## Verification
The hardest state to reach is a retransmit that follows a partial drain. The occupancy then jumps from a small value back to the write address and can cross the half-full threshold in one step. A directed sequence writes 300 words, reads 100, rewinds, and checks that all 300 come back in order with half_n low again. Full and empty are each held while strobes keep arriving, to show that refused accesses have no effect. A long seeded random phase mixes rare rewinds and resets with wrap-around of both addresses, and a bench model built from the requirements checks every cycle.

// File: rtl/fifo_rt.sv
module fifo_rt #(
  parameter int DW    = 9,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          rt_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  wire is_full  = (cnt == (AW+1)'(DEPTH));
  wire is_empty = (cnt == '0);
  wire live     = rst_n & rt_n;
  wire do_wr    = live & ~wr_n & ~is_full;
  wire do_rd    = live & ~rd_n & ~is_empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (do_wr) mem[wp] <= din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      dout <= '0;
    end else if (!rt_n) begin
      rp  <= '0;
      cnt <= {1'b0, wp};
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) begin
        rp   <= bump(rp);
        dout <= mem[rp];
      end
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign empty_n = ~is_empty;
  assign full_n  = ~is_full;
  assign half_n  = ~(cnt > (AW+1)'(HALF));

endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int DW    = 9,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_n,
  input logic          rd_n,
  input logic          rt_n,
  input logic [DW-1:0] dout,
  input logic          empty_n,
  input logic          full_n,
  input logic          half_n,
  input logic [AW-1:0] wp,
  input logic [AW-1:0] rp,
  input logic [AW:0]   cnt
);

  p_reset_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!empty_n && full_n && half_n && dout == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !wr_n && rd_n && rt_n) |=> (!full_n && $stable(wp) && $stable(dout)));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !rd_n && rt_n) |=> ($stable(dout) && $stable(rp)));

  p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n));

  p_half_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !half_n);

  p_half_when_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> half_n);

  p_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> (rp == '0 && wp == $past(wp) && cnt == {1'b0, $past(wp)}));

  p_dout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || !rt_n) |=> $stable(dout));

endmodule

bind fifo_rt fifo_rt_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
  .dout(dout), .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
  .wp(wp), .rp(rp), .cnt(cnt)
);

// File: tb/sim_fifo_rt.sv
`timescale 1ns/1ps
module sim_fifo_rt;
  localparam int DW = 9;
  localparam int DEPTH = 512;

  logic clk = 0;
  logic rst_n = 0, wr_n = 1, rd_n = 1, rt_n = 1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic empty_n, full_n, half_n;

  fifo_rt u0 (.clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
              .din(din), .dout(dout), .empty_n(empty_n), .full_n(full_n), .half_n(half_n));

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [DW-1:0] m_mem [DEPTH];
  int m_wp = 0, m_rp = 0, m_cnt = 0;
  logic [DW-1:0] m_q = '0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model(input bit rs, input bit t, input bit w, input bit r, input logic [DW-1:0] d);
    bit dw, dr;
    if (!rs) begin
      m_wp = 0; m_rp = 0; m_cnt = 0; m_q = '0;
    end else if (!t) begin
      m_rp = 0; m_cnt = m_wp;
    end else begin
      dw = !w && m_cnt != DEPTH;
      dr = !r && m_cnt != 0;
      if (dr) begin m_q = m_mem[m_rp]; m_rp = (m_rp + 1) % DEPTH; end
      if (dw) begin m_mem[m_wp] = d; m_wp = (m_wp + 1) % DEPTH; end
      m_cnt = m_cnt + int'(dw) - int'(dr);
    end
  endtask

  task automatic compare(input string tag);
    check(empty_n == (m_cnt != 0), tag, "empty_n", int'(empty_n), int'(m_cnt != 0));
    check(full_n == (m_cnt != DEPTH), tag, "full_n", int'(full_n), int'(m_cnt != DEPTH));
    check(half_n == (m_cnt <= DEPTH/2), tag, "half_n", int'(half_n), int'(m_cnt <= DEPTH/2));
    check(dout == m_q, tag, "dout", int'(dout), int'(m_q));
  endtask

  task automatic step(input bit rs, input bit t, input bit w, input bit r,
                      input logic [DW-1:0] d, input string tag);
    rst_n = rs; rt_n = t; wr_n = w; rd_n = r; din = d;
    @(posedge clk);
    model(rs, t, w, r, d);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R10: reset with retransmit and strobes active
    step(0, 0, 0, 0, 9'h1AA, "R10");
    step(0, 1, 1, 1, 0, "R2");
    check(!empty_n && full_n && half_n && dout == 0, "R2", "reset state", int'({empty_n, full_n, half_n}), 3'b011);

    // R4: read while empty ignored
    step(1, 1, 1, 0, 0, "R4");
    // R9: both strobes while empty -> write only
    step(1, 1, 0, 0, 9'h055, "R9");
    step(1, 1, 1, 0, 0, "R8");
    check(dout == 9'h055, "R8", "first read", int'(dout), 9'h055);

    // Fill to full, R6 threshold, R5 full flag
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 1, 0, 1, 9'((i * 37 + 5)), "R6");
      if (i == 255) check(half_n == 1, "R6", "half_n at 256", int'(half_n), 1);
      if (i == 256) check(half_n == 0, "R6", "half_n at 257", int'(half_n), 0);
    end
    check(full_n == 0, "R5", "full_n at 512", int'(full_n), 0);
    // R3: writes while full ignored
    for (int i = 0; i < 5; i++) step(1, 1, 0, 1, 9'h1FF, "R3");
    // R9: both while full -> read only
    step(1, 1, 0, 0, 9'h1EE, "R9");
    check(full_n == 1, "R9", "full_n after rd+wr at full", int'(full_n), 1);
    // Drain, R1 order
    for (int i = 0; i < DEPTH; i++) step(1, 1, 1, 0, 0, "R1");
    check(empty_n == 0, "R5", "empty_n after drain", int'(empty_n), 0);
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 0, "R4");

    // R7: retransmit after partial drain
    step(0, 1, 1, 1, 0, "R2");
    for (int i = 0; i < 300; i++) step(1, 1, 0, 1, 9'(i * 11 + 3), "R7");
    for (int i = 0; i < 100; i++) step(1, 1, 1, 0, 0, "R7");
    check(half_n == 1, "R6", "half_n at 200", int'(half_n), 1);
    step(1, 0, 0, 0, 9'h123, "R7");
    check(half_n == 0, "R7", "half_n after rewind (300)", int'(half_n), 0);
    for (int i = 0; i < 300; i++) begin
      step(1, 1, 1, 0, 0, "R7");
      check(dout == 9'(i * 11 + 3), "R7", "reread word", int'(dout), int'(9'(i * 11 + 3)));
    end
    check(empty_n == 0, "R7", "empty after reread", int'(empty_n), 0);

    // Random traffic
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 40000; i++) begin
      int ph = (i / 4000) % 3;
      bit w = ($urandom_range(0, 99) < (ph == 0 ? 70 : ph == 1 ? 30 : 50)) ? 1'b0 : 1'b1;
      bit r = ($urandom_range(0, 99) < (ph == 0 ? 30 : ph == 1 ? 70 : 50)) ? 1'b0 : 1'b1;
      bit t = ($urandom_range(0, 999) < 3) ? 1'b0 : 1'b1;
      bit rs = ($urandom_range(0, 9999) < 2) ? 1'b0 : 1'b1;
      step(rs, t, w, r, 9'($urandom), "R9");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule